// File: doc/BRIEF.md
# Self-Calibrating Serial Command Receiver

This block accepts characters on an asynchronous serial line whose bit rate is unknown when the block leaves reset. Until it has learned the rate, it only observes the line. Every frame that starts with a falling edge is timed. The shortest run of constant level inside the frame is taken as that frame's bit period, and the number of level transitions is counted as a rough signature of the character. The operator sends the same character repeatedly. Once enough consecutive frames agree on both the signature and the period, the block locks to the period of the latest frame.

After lock, the block receives 8N1 frames by sampling each bit at its centre. It echoes every received byte back on its transmit line at the learned rate. A small decoder turns six command characters into single-cycle pan and zoom strobes.

A select input chooses the source that feeds the decoder. The source is either this serial receiver or an alternate character input, such as a remote-control decoder. The two sources are switched between, never merged. A disturbed alternate source therefore cannot corrupt commands while the serial source is selected.

Top module: `autobaud_cmd_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `locked_o` is 0, `tx_o` is 1 and all strobe outputs are 0.
- R2: The learned bit period equals the shortest constant-level run measured in clock cycles within a captured frame. The run counter saturates at its maximum, which is 2^CNT_W-1.
- R3: Lock is taken only after LOCK_RUNS (default 6) consecutive captures match. Two captures match when their transition counts are equal and their periods differ by at most one eighth of the earlier period. A non-matching capture restarts the run at 1. Once `locked_o` is 1, it stays 1 until reset.
- R4: After lock, a frame is 1 start bit (0), 8 data bits sent LSB first, and 1 stop bit (1), with no parity. Each bit is sampled half a bit period after the start edge plus whole bit periods. A start bit that reads 1 at its centre is discarded, and the receiver re-syncs on the next falling edge. A frame whose stop bit reads 0 is dropped.
- R5: Every byte received after lock is transmitted on `tx_o` as an 8N1 frame at the learned bit period.
- R6: One cycle after a selected character arrives, the matching strobe pulses for one cycle. The bits of `pan_o` are: bit0 up for 'w' (0x77), bit1 down for 's' (0x73), bit2 left for 'a' (0x61) and bit3 right for 'd' (0x64). The bits of `zoom_o` are: bit0 zoom in for '+' (0x2B) and bit1 zoom out for '-' (0x2D).
- R7: Any other character produces no strobe.
- R8: When `src_sel_i`=0, the decoder takes serial characters. When `src_sel_i`=1, it takes `alt_cmd_i` whenever `alt_valid_i` is high. The unselected source has no effect on the strobes, though serial bytes are still echoed.
- R9: At most one strobe bit is high in any cycle.
- R10: Before lock, `tx_o` stays 1 and serial characters produce no strobes.
- R11: Asserting reset after lock returns the block to the unlocked measuring state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| src_sel_i | input | 1 | Command source select: 0 serial, 1 alternate |
| alt_valid_i | input | 1 | Alternate character valid strobe |
| alt_cmd_i | input | 8 | Alternate command character |
| tx_o | output | 1 | Serial echo line, idle high |
| locked_o | output | 1 | Bit rate learned |
| pan_o | output | 4 | Pan strobes {right, left, down, up} |
| zoom_o | output | 2 | Zoom strobes {out, in} |

## Verification
The bench builds the block with its default values, CNT_W=16 and LOCK_RUNS=6. It drives the line at 16 clocks per bit. At that rate the measured period is exact and the half-period wait lands on a whole cycle. The full lock run, including the five-capture near miss and the restart forced by a different character, fits in a few thousand cycles. The 16-bit counter gives ample headroom for the 11-period end-of-frame timeout used while measuring.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam logic [7:0] CH_UP    = 8'h77;
  localparam logic [7:0] CH_DOWN  = 8'h73;
  localparam logic [7:0] CH_LEFT  = 8'h61;
  localparam logic [7:0] CH_RIGHT = 8'h64;
  localparam logic [7:0] CH_ZIN   = 8'h2B;
  localparam logic [7:0] CH_ZOUT  = 8'h2D;

  typedef enum logic {MS_IDLE, MS_RUN} meas_st_e;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  typedef struct packed {
    logic zoom_out;
    logic zoom_in;
    logic right;
    logic left;
    logic down;
    logic up;
  } cmd_t;
endpackage

// File: rtl/abr_measure.sv
module abr_measure import abr_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUNS = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int HIT_W  = $clog2(LOCK_RUNS + 1);
  localparam int EDGE_W = 5;
  localparam int LIM_W  = CNT_W + 4;

  meas_st_e          st_q;
  logic              line_q;
  logic [CNT_W-1:0]  run_q, min_q, prev_min_q;
  logic [EDGE_W-1:0] edges_q, prev_edges_q;
  logic [HIT_W-1:0]  hits_q, hits_nx;

  logic             edge_w, run_sat, ch_end, match;
  logic [LIM_W-1:0] end_lim, min_ext;
  logic [CNT_W-1:0] diff;

  assign edge_w  = line_i ^ line_q;
  assign run_sat = &run_q;
  assign min_ext = LIM_W'(min_q);
  // frame over once the line has stayed high for 11 measured periods
  assign end_lim = (min_ext << 3) + (min_ext << 1) + min_ext;
  assign ch_end  = (st_q == MS_RUN) && line_i && !edge_w &&
                   ((LIM_W'(run_q) >= end_lim) || run_sat);
  assign diff    = (min_q > prev_min_q) ? min_q - prev_min_q : prev_min_q - min_q;
  assign match   = (edges_q == prev_edges_q) && (diff <= (prev_min_q >> 3));
  assign hits_nx = (hits_q != '0 && match) ? hits_q + 1'b1 : HIT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= MS_IDLE;
      line_q       <= 1'b1;
      run_q        <= '0;
      min_q        <= '1;
      prev_min_q   <= '1;
      edges_q      <= '0;
      prev_edges_q <= '0;
      hits_q       <= '0;
      locked_o     <= 1'b0;
      period_o     <= '0;
    end else begin
      line_q <= line_i;
      case (st_q)
        MS_IDLE: begin
          if (!locked_o && edge_w && !line_i) begin
            st_q    <= MS_RUN;
            run_q   <= CNT_W'(1);
            min_q   <= '1;
            edges_q <= '0;
          end
        end
        default: begin
          if (ch_end) begin
            st_q         <= MS_IDLE;
            prev_min_q   <= min_q;
            prev_edges_q <= edges_q;
            hits_q       <= hits_nx;
            if (hits_nx == HIT_W'(LOCK_RUNS)) begin
              locked_o <= 1'b1;
              period_o <= min_q;
            end
          end else if (edge_w) begin
            if (run_q < min_q) min_q <= run_q;
            if (!(&edges_q)) edges_q <= edges_q + 1'b1;
            run_q <= CNT_W'(1);
          end else if (!run_sat) begin
            run_q <= run_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/abr_rx.sv
module abr_rx import abr_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             valid_o,
  output logic [7:0]       data_o
);
  rx_st_e           st_q;
  logic             line_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic             tick;

  assign tick = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RX_IDLE;
      line_q  <= 1'b1;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      line_q  <= line_i;
      valid_o <= 1'b0;
      if (!tick) cnt_q <= cnt_q - 1'b1;
      case (st_q)
        RX_IDLE: if (en_i && line_q && !line_i) begin
          st_q  <= RX_START;
          cnt_q <= period_i >> 1;
        end
        RX_START: if (tick) begin
          if (line_i) st_q <= RX_IDLE;  // glitch, re-sync
          else begin
            st_q  <= RX_DATA;
            cnt_q <= period_i;
            bit_q <= '0;
          end
        end
        RX_DATA: if (tick) begin
          sh_q  <= {line_i, sh_q[7:1]};
          bit_q <= bit_q + 1'b1;
          cnt_q <= period_i;
          if (bit_q == 3'd7) st_q <= RX_STOP;
        end
        default: if (tick) begin
          st_q <= RX_IDLE;
          if (line_i) begin
            valid_o <= 1'b1;
            data_o  <= sh_q;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/abr_tx.sv
module abr_tx #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             send_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             tx_o
);
  logic             busy_q;
  logic [8:0]       sh_q;
  logic [3:0]       left_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      cnt_q  <= '0;
      tx_o   <= 1'b1;
    end else if (!busy_q) begin
      if (send_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i};
        left_q <= 4'd9;
        cnt_q  <= period_i;
        tx_o   <= 1'b0;
      end
    end else if (cnt_q <= CNT_W'(1)) begin
      cnt_q <= period_i;
      if (left_q == '0) busy_q <= 1'b0;
      else begin
        tx_o   <= sh_q[0];
        sh_q   <= {1'b1, sh_q[8:1]};
        left_q <= left_q - 1'b1;
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/abr_cmd_dec.sv
module abr_cmd_dec import abr_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] char_i,
  output cmd_t       cmd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_o <= '0;
    else begin
      cmd_o <= '0;
      if (valid_i) begin
        case (char_i)
          CH_UP:    cmd_o.up       <= 1'b1;
          CH_DOWN:  cmd_o.down     <= 1'b1;
          CH_LEFT:  cmd_o.left     <= 1'b1;
          CH_RIGHT: cmd_o.right    <= 1'b1;
          CH_ZIN:   cmd_o.zoom_in  <= 1'b1;
          CH_ZOUT:  cmd_o.zoom_out <= 1'b1;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/autobaud_cmd_rx.sv
module autobaud_cmd_rx import abr_pkg::*; #(
  parameter int CNT_W     = 16,
  parameter int LOCK_RUNS = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       src_sel_i,
  input  logic       alt_valid_i,
  input  logic [7:0] alt_cmd_i,
  output logic       tx_o,
  output logic       locked_o,
  output logic [3:0] pan_o,
  output logic [1:0] zoom_o
);
  logic [1:0]       sync_q;
  logic             line_s;
  logic [CNT_W-1:0] period;
  logic             rx_valid, sel_valid;
  logic [7:0]       rx_data, sel_char;
  cmd_t             cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign line_s = sync_q[1];

  abr_measure #(.CNT_W(CNT_W), .LOCK_RUNS(LOCK_RUNS)) u_meas (
    .clk_i, .rst_ni, .line_i(line_s), .locked_o, .period_o(period)
  );

  abr_rx #(.CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .en_i(locked_o), .line_i(line_s), .period_i(period),
    .valid_o(rx_valid), .data_o(rx_data)
  );

  abr_tx #(.CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .send_i(rx_valid), .data_i(rx_data), .period_i(period), .tx_o
  );

  // switch, never merge, the two command sources
  assign sel_valid = src_sel_i ? alt_valid_i : rx_valid;
  assign sel_char  = src_sel_i ? alt_cmd_i   : rx_data;

  abr_cmd_dec u_dec (
    .clk_i, .rst_ni, .valid_i(sel_valid), .char_i(sel_char), .cmd_o(cmd)
  );

  assign pan_o  = {cmd.right, cmd.left, cmd.down, cmd.up};
  assign zoom_o = {cmd.zoom_out, cmd.zoom_in};
endmodule

// File: rtl/abr_chk.sv
module abr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       locked_i,
  input logic       tx_i,
  input logic       sel_valid_i,
  input logic [3:0] pan_i,
  input logic [1:0] zoom_i
);
  // R9
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({zoom_i, pan_i}));

  // R6
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{zoom_i, pan_i}) |-> $past(sel_valid_i));

  // R3
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> locked_i);

  // R10
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |-> tx_i);
endmodule

bind autobaud_cmd_rx abr_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .locked_i(locked_o), .tx_i(tx_o),
  .sel_valid_i(sel_valid), .pan_i(pan_o), .zoom_i(zoom_o)
);

// File: tb/autobaud_cmd_rx_tb.sv
module autobaud_cmd_rx_tb;
  localparam int BIT = 16;
  localparam int GAP = 240;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       src_sel = 1'b0;
  logic       alt_valid = 1'b0;
  logic [7:0] alt_cmd = '0;
  logic       tx, locked;
  logic [3:0] pan_o;
  logic [1:0] zoom_o;

  int total = 0;
  int bad = 0;
  logic [7:0] echo_q[$];
  logic [5:0] cmd_q[$];
  logic [7:0] mon_byte;
  logic [5:0] cur, prev;

  always #10 clk = ~clk;

  autobaud_cmd_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .src_sel_i(src_sel),
    .alt_valid_i(alt_valid), .alt_cmd_i(alt_cmd), .tx_o(tx), .locked_o(locked),
    .pan_o(pan_o), .zoom_o(zoom_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c, input logic echo, input logic [5:0] cmd);
    if (echo) echo_q.push_back(c);
    if (cmd != '0) cmd_q.push_back(cmd);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(c[i]);
    drive_bit(1'b1);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_alt(input logic [7:0] c, input logic [5:0] cmd);
    if (cmd != '0) cmd_q.push_back(cmd);
    @(negedge clk);
    alt_valid = 1'b1;
    alt_cmd   = c;
    @(negedge clk);
    alt_valid = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // echo monitor: decodes tx at the known rate, pops expected bytes (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && tx === 1'b0) begin
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          mon_byte[i] = tx;
        end
        repeat (BIT) @(negedge clk);
        check("R5 echo stop bit", {7'b0, tx}, 8'h1);
        if (echo_q.size() == 0) check("R5/R10 unexpected echo", mon_byte, 8'hxx);
        else check("R5 echo byte", mon_byte, echo_q.pop_front());
      end
    end
  end

  // strobe monitor (R6, R7, R8, R9, R10)
  initial begin
    prev = '0;
    forever begin
      @(negedge clk);
      cur = {zoom_o, pan_o};
      if (rst_n && cur != '0) begin
        check("R9 single-cycle strobe", {7'b0, cur == prev}, 8'h0);
        if (cmd_q.size() == 0) check("R7/R8/R10 unexpected strobe", {2'b0, cur}, 8'h0);
        else check("R6 strobe", {2'b0, cur}, {2'b0, cmd_q.pop_front()});
      end
      prev = cur;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    check("R1 locked in reset", {7'b0, locked}, 8'h0);
    check("R1 tx in reset", {7'b0, tx}, 8'h1);
    check("R1 strobes in reset", {2'b0, zoom_o, pan_o}, 8'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 locked after reset", {7'b0, locked}, 8'h0);

    // R3: five matches are not enough; R10 no echo, no strobe
    for (int i = 0; i < 5; i++) send_char(8'h77, 1'b0, 6'b0);
    check("R3 five captures", {7'b0, locked}, 8'h0);
    // R3: a different character restarts the run
    send_char(8'h55, 1'b0, 6'b0);
    for (int i = 0; i < 5; i++) send_char(8'h77, 1'b0, 6'b0);
    check("R3 restart after mismatch", {7'b0, locked}, 8'h0);
    send_char(8'h77, 1'b0, 6'b0);
    check("R3 lock on sixth match", {7'b0, locked}, 8'h1);

    // R2, R4, R5, R6: commands at the learned rate
    send_char(8'h77, 1'b1, 6'b000001);
    send_char(8'h61, 1'b1, 6'b000100);
    send_char(8'h73, 1'b1, 6'b000010);
    send_char(8'h64, 1'b1, 6'b001000);
    send_char(8'h2B, 1'b1, 6'b010000);
    send_char(8'h2D, 1'b1, 6'b100000);
    // R7: unknown characters echo but do not strobe
    send_char(8'h78, 1'b1, 6'b0);
    send_char(8'h00, 1'b1, 6'b0);

    // R4: short glitch is discarded, next frame still received
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (GAP) @(negedge clk);
    send_char(8'h61, 1'b1, 6'b000100);

    // R8: alternate source selected, serial ignored for commands
    src_sel = 1'b1;
    send_char(8'h64, 1'b1, 6'b0);
    send_alt(8'h2B, 6'b010000);
    send_alt(8'h78, 6'b0);
    src_sel = 1'b0;
    send_alt(8'h73, 6'b0);

    repeat (400) @(negedge clk);
    check("R5 echo queue drained", 8'(echo_q.size()), 8'h0);
    check("R6 command queue drained", 8'(cmd_q.size()), 8'h0);
    check("R3 lock held", {7'b0, locked}, 8'h1);

    // R11
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 unlocked in reset", {7'b0, locked}, 8'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 unlocked after reset", {7'b0, locked}, 8'h0);
    send_char(8'h77, 1'b0, 6'b0);
    check("R11 measuring again, no lock", {7'b0, locked}, 8'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule